// File: doc/BRIEF.md
# Contiguous Free-Entry Allocator

This block keeps the valid bits that shadow a translation table and searches them for a run of consecutive free entries. A request names a byte address, a byte length and a page size given as a shift. The block works out how many pages the byte range touches, counting a partial first page when the start address is not page-aligned. It then searches a pool of entries for the lowest start index at which that many consecutive entries are all free.

The pool is either an explicit first index and size, or one of two preset pools. The paged pool holds every entry above a reserved low region. A super-page pool is one fixed-size slice of the reserved region, picked by a port number. The search is first-fit and evaluates one candidate start per clock. When the search succeeds, the run can be marked valid in the same cycle the result is reported, so a request that follows at once cannot claim any of those entries. A release port clears a run of valid bits in one cycle.

Top module: `contig_run_alloc`

## Requirements
- R1: After reset, `valid_o` is all zeros, and `busy_o`, `done_o` and `ok_o` are low.
- R2: The entry count N is `((addr + len - 1) >> shift) - (addr >> shift) + 1`, evaluated without overflow. A request with `req_len` = 0 fails immediately.
- R3: If N is larger than the pool size, the request fails immediately. `done_o` rises with `ok_o` = 0 one cycle after acceptance, `busy_o` stays low and no valid bit changes.
- R4: The candidate starts run from the pool's first index up to first + size - N, inclusive. The result `idx_o` is the lowest candidate whose N entries are all invalid.
- R5: A request is accepted when `req_valid` is high while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the result. The candidate j positions past the first is evaluated at the (j+1)-th edge after acceptance, so `done_o` is seen j+2 cycles after acceptance. `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R6: If every candidate has a valid entry in its window, `done_o` rises with `ok_o` = 0 after the last candidate is evaluated.
- R7: On success with `req_mark` = 1, entries `idx_o` .. `idx_o`+N-1 read as valid in the same cycle that `done_o` is high. With `req_mark` = 0, the valid bits are left unchanged.
- R8: `req_pool` = 1 selects the paged pool: first index 64 (the reserved count) and size 64 (entries 64..127).
- R9: `req_pool` = 2 selects a super-page pool: first index `req_port` × 32 and size 32. `req_pool` = 3 fails immediately. `req_pool` = 0 uses `req_first` and `req_size`.
- R10: A `rel_valid` pulse while idle clears `rel_count` entries starting at `rel_first`, clipped at the last table entry, and the cleared bits show on `valid_o` in the next cycle. A count of 0 changes nothing. A request in the same cycle scans the already-released vector.
- R11: While `busy_o` is high, `rel_valid` and `req_valid` are ignored, and no valid bit is cleared.
- R12: An explicit pool whose first index plus size exceeds the table size fails immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request strobe |
| req_pool | input | 2 | Pool select: 0 explicit, 1 paged, 2 super-page, 3 invalid |
| req_port | input | 1 | Super-page slice number |
| req_first | input | 7 | First index of an explicit pool |
| req_size | input | 8 | Size of an explicit pool |
| req_addr | input | 32 | Byte address to be covered |
| req_len | input | 24 | Byte length to be covered |
| req_shift | input | 5 | log2 of the page size in bytes |
| req_mark | input | 1 | Mark the found run valid on success |
| rel_valid | input | 1 | Release strobe |
| rel_first | input | 7 | First index to release |
| rel_count | input | 8 | Number of entries to release |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Result success flag, held until the next result |
| idx_o | output | 7 | Start index of the found run, held |
| valid_o | output | 128 | Valid-bit vector of the table |

## Verification
The hardest situation to reach from the ports is a release or a new request that arrives while a search is still running. Only a search that must step over several occupied candidates stays busy long enough for that. The stimulus first fills low entries with marked allocations. It then issues a one-entry search that must skip two occupied starts, and drives a release of exactly those occupied entries together with an invalid-pool request during the busy cycles. Afterwards the bench confirms that the entries are still valid and that no second result strobe appears.

// File: rtl/cra_pkg.sv
package cra_pkg;

    // Pool selection codes seen on req_pool
    typedef enum logic [1:0] {
        POOL_EXPLICIT = 2'd0,
        POOL_PAGED    = 2'd1,
        POOL_SUPER    = 2'd2,
        POOL_NONE     = 2'd3
    } pool_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // Pages touched by the byte range [addr, addr+len-1]; len must be nonzero.
    function automatic logic [63:0] page_span(input logic [63:0] addr,
                                              input logic [63:0] len,
                                              input logic [5:0]  shift);
        logic [63:0] last_byte;
        last_byte = addr + len - 64'd1;
        return (last_byte >> shift) - (addr >> shift) + 64'd1;
    endfunction

endpackage

// File: rtl/cra_page_count.sv
module cra_page_count
    import cra_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 24,
    parameter int SHIFT_W = 5,
    parameter int NEED_W  = 9
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LEN_W-1:0]   len,
    input  logic [SHIFT_W-1:0] shift,
    output logic [NEED_W-1:0]  need,
    output logic               empty
);
    localparam logic [NEED_W-1:0] SAT = '1;

    logic [63:0] span;

    assign span  = page_span(64'(addr), 64'(len), 6'(shift));
    // saturate: any count beyond NEED_W is larger than every pool
    assign need  = (span > 64'(SAT)) ? SAT : span[NEED_W-1:0];
    assign empty = (len == '0);

endmodule

// File: rtl/cra_window_check.sv
module cra_window_check #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = 7
) (
    input  logic [ENTRIES-1:0] vec,
    input  logic [ENTRIES-1:0] need_mask,
    input  logic [IDX_W-1:0]   cand,
    output logic               clash
);
    logic [ENTRIES-1:0] win;
    logic [ENTRIES-1:0] hit;

    assign win = vec >> cand;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_hit
        assign hit[i] = need_mask[i] & win[i];
    end

    assign clash = |hit;

endmodule

// File: rtl/cra_valid_store.sv
module cra_valid_store #(
    parameter int ENTRIES = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] set_mask,
    input  logic [ENTRIES-1:0] clr_mask,
    output logic [ENTRIES-1:0] vec
);
    logic [ENTRIES-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            vec_q <= (vec_q & ~clr_mask) | set_mask;
        end
    end

    assign vec = vec_q;

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask & clr_mask) == '0);

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0 && clr_mask == '0) |=> $stable(vec_q));

endmodule

// File: rtl/contig_run_alloc.sv
module contig_run_alloc
    import cra_pkg::*;
#(
    parameter int ENTRIES       = 128,
    parameter int RSVD_ENTRIES  = 64,
    parameter int SLICE_ENTRIES = 32,
    parameter int ADDR_W        = 32,
    parameter int LEN_W         = 24,
    parameter int SHIFT_W       = 5,
    localparam int IDX_W        = $clog2(ENTRIES),
    localparam int CNT_W        = IDX_W + 1,
    localparam int NUM_SLICES   = RSVD_ENTRIES / SLICE_ENTRIES,
    localparam int PORT_W       = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_pool,
    input  logic [PORT_W-1:0]  req_port,
    input  logic [IDX_W-1:0]   req_first,
    input  logic [CNT_W-1:0]   req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [SHIFT_W-1:0] req_shift,
    input  logic               req_mark,
    input  logic               rel_valid,
    input  logic [IDX_W-1:0]   rel_first,
    input  logic [CNT_W-1:0]   rel_count,
    output logic               busy_o,
    output logic               done_o,
    output logic               ok_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [ENTRIES-1:0] valid_o
);
    localparam int SUM_W = CNT_W + 1;

    scan_state_e        state_q;
    logic [IDX_W-1:0]   cand_q;
    logic [SUM_W-1:0]   last_q;
    logic [SUM_W-1:0]   first_q;
    logic [ENTRIES-1:0] mask_q;
    logic               mark_q;
    logic               done_q;
    logic               ok_q;
    logic [IDX_W-1:0]   idx_q;

    logic [SUM_W-1:0]   pool_first;
    logic [SUM_W-1:0]   pool_size;
    logic               pool_bad;
    logic [SUM_W-1:0]   need;
    logic               len_empty;
    logic               req_fail;
    logic [SUM_W-1:0]   last_d;
    logic [ENTRIES-1:0] need_mask_d;
    logic [ENTRIES-1:0] rel_mask;
    logic [ENTRIES-1:0] set_mask;
    logic [ENTRIES-1:0] clr_mask;
    logic               clash;
    logic               idle;
    logic               hit_ok;

    assign idle = (state_q == ST_IDLE);

    // ---------------- pool resolution ----------------
    always_comb begin
        pool_first = '0;
        pool_size  = '0;
        pool_bad   = 1'b0;
        unique case (pool_sel_e'(req_pool))
            POOL_EXPLICIT: begin
                pool_first = SUM_W'(req_first);
                pool_size  = SUM_W'(req_size);
            end
            POOL_PAGED: begin
                pool_first = SUM_W'(RSVD_ENTRIES);
                pool_size  = SUM_W'(ENTRIES - RSVD_ENTRIES);
            end
            POOL_SUPER: begin
                pool_first = SUM_W'(req_port) * SUM_W'(SLICE_ENTRIES);
                pool_size  = SUM_W'(SLICE_ENTRIES);
                pool_bad   = (32'(req_port) >= NUM_SLICES);
            end
            default: pool_bad = 1'b1;
        endcase
    end

    cra_page_count #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SHIFT_W(SHIFT_W),
        .NEED_W (SUM_W)
    ) i_page_count (
        .addr (req_addr),
        .len  (req_len),
        .shift(req_shift),
        .need (need),
        .empty(len_empty)
    );

    assign req_fail = pool_bad || len_empty ||
                      ((pool_first + pool_size) > SUM_W'(ENTRIES)) ||
                      (need > pool_size);
    assign last_d   = pool_first + pool_size - need;

    // ---------------- mask builders ----------------
    for (genvar i = 0; i < ENTRIES; i++) begin : g_mask
        assign need_mask_d[i] = (SUM_W'(i) < need);
        assign rel_mask[i]    = (SUM_W'(i) >= SUM_W'(rel_first)) &&
                                (SUM_W'(i) <  SUM_W'(rel_first) + SUM_W'(rel_count));
    end

    // ---------------- search window ----------------
    cra_window_check #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) i_window (
        .vec      (valid_o),
        .need_mask(mask_q),
        .cand     (cand_q),
        .clash    (clash)
    );

    assign hit_ok   = (state_q == ST_SCAN) && !clash;
    assign set_mask = (hit_ok && mark_q) ? (mask_q << cand_q) : '0;
    assign clr_mask = (idle && rel_valid) ? rel_mask : '0;

    cra_valid_store #(
        .ENTRIES(ENTRIES)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .vec     (valid_o)
    );

    // ---------------- control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            last_q  <= '0;
            first_q <= '0;
            mask_q  <= '0;
            mark_q  <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        mark_q <= req_mark;
                        if (req_fail) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b0;
                            idx_q  <= '0;
                        end else begin
                            state_q <= ST_SCAN;
                            cand_q  <= pool_first[IDX_W-1:0];
                            first_q <= pool_first;
                            last_q  <= last_d;
                            mask_q  <= need_mask_d;
                        end
                    end
                end
                ST_SCAN: begin
                    if (!clash) begin
                        done_q  <= 1'b1;
                        ok_q    <= 1'b1;
                        idx_q   <= cand_q;
                        state_q <= ST_IDLE;
                    end else if (SUM_W'(cand_q) == last_q) begin
                        done_q  <= 1'b1;
                        ok_q    <= 1'b0;
                        idx_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cand_q <= cand_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == ST_SCAN);
    assign done_o = done_q;
    assign ok_o   = ok_q;
    assign idx_o  = idx_q;

    // ---------------- checks ----------------
    // R5
    no_busy_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R4
    cand_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (SUM_W'(cand_q) <= last_q));

    // R4
    result_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> (SUM_W'(idx_o) >= first_q && SUM_W'(idx_o) <= last_q));

    // R7
    mark_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o && mark_q) |-> (((valid_o >> idx_o) & mask_q) == mask_q));

    // R11
    no_clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ((valid_o & $past(valid_o)) == $past(valid_o)));

endmodule

// File: tb/test_contig_run_alloc.sv
`timescale 1ns/1ps
module test_contig_run_alloc;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [1:0]   req_pool;
    logic [0:0]   req_port;
    logic [6:0]   req_first;
    logic [7:0]   req_size;
    logic [31:0]  req_addr;
    logic [23:0]  req_len;
    logic [4:0]   req_shift;
    logic         req_mark;
    logic         rel_valid;
    logic [6:0]   rel_first;
    logic [7:0]   rel_count;
    logic         busy_o;
    logic         done_o;
    logic         ok_o;
    logic [6:0]   idx_o;
    logic [127:0] valid_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    contig_run_alloc i_contig_run_alloc (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_pool(req_pool), .req_port(req_port),
        .req_first(req_first), .req_size(req_size), .req_addr(req_addr),
        .req_len(req_len), .req_shift(req_shift), .req_mark(req_mark),
        .rel_valid(rel_valid), .rel_first(rel_first), .rel_count(rel_count),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .idx_o(idx_o),
        .valid_o(valid_o)
    );

    typedef struct packed {
        logic [1:0]  pool;
        logic [0:0]  port;
        logic [6:0]  first;
        logic [7:0]  size;
        logic [31:0] addr;
        logic [23:0] len;
        logic [4:0]  shift;
        logic        mark;
        logic        eok;
        logic [6:0]  eidx;
        logic [7:0]  elat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'd0, 7'd0,   8'd16, 32'h000, 24'd48,   5'd4, 1'b1, 1'b1, 7'd0,  8'd2}, // R4 N=3
        '{2'd0, 1'd0, 7'd0,   8'd16, 32'h008, 24'd16,   5'd4, 1'b1, 1'b1, 7'd3,  8'd5}, // R2 misaligned N=2
        '{2'd0, 1'd0, 7'd2,   8'd6,  32'h100, 24'd64,   5'd4, 1'b1, 1'b0, 7'd0,  8'd4}, // R6 exhausted
        '{2'd0, 1'd0, 7'd0,   8'd16, 32'h000, 24'd0,    5'd4, 1'b1, 1'b0, 7'd0,  8'd1}, // R2 zero length
        '{2'd0, 1'd0, 7'd0,   8'd4,  32'h000, 24'd80,   5'd4, 1'b1, 1'b0, 7'd0,  8'd1}, // R3 N=5>4
        '{2'd0, 1'd0, 7'd120, 8'd16, 32'h000, 24'd1,    5'd4, 1'b1, 1'b0, 7'd0,  8'd1}, // R12 past end
        '{2'd1, 1'd0, 7'd0,   8'd0,  32'h040, 24'd1024, 5'd4, 1'b0, 1'b1, 7'd64, 8'd2}, // R8 N=64 no mark
        '{2'd1, 1'd0, 7'd0,   8'd0,  32'h040, 24'd1040, 5'd4, 1'b1, 1'b0, 7'd0,  8'd1}, // R3 N=65
        '{2'd2, 1'd1, 7'd0,   8'd0,  32'h000, 24'd1,    5'd4, 1'b1, 1'b1, 7'd32, 8'd2}, // R9 slice 1
        '{2'd2, 1'd1, 7'd0,   8'd0,  32'h000, 24'd512,  5'd4, 1'b1, 1'b0, 7'd0,  8'd2}, // R6 single candidate
        '{2'd2, 1'd0, 7'd0,   8'd0,  32'h000, 24'd32,   5'd4, 1'b0, 1'b1, 7'd5,  8'd7}, // R9 slice 0
        '{2'd3, 1'd0, 7'd0,   8'd0,  32'h000, 24'd1,    5'd4, 1'b1, 1'b0, 7'd0,  8'd1}, // R9 select 3
        '{2'd0, 1'd0, 7'd64,  8'd8,  32'h1F0, 24'h20,   5'd8, 1'b1, 1'b1, 7'd64, 8'd2}, // R2 shift 8
        '{2'd1, 1'd0, 7'd0,   8'd0,  32'h000, 24'd1,    5'd4, 1'b1, 1'b1, 7'd66, 8'd4}  // R8 skip two
    };

    function automatic string vtag(input int k);
        case (k)
            0: return "R4";  1: return "R2";  2: return "R6";  3: return "R2";
            4: return "R3";  5: return "R12"; 6: return "R8";  7: return "R3";
            8: return "R9";  9: return "R6";  10: return "R9"; 11: return "R9";
            12: return "R2"; default: return "R8";
        endcase
    endfunction

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_req(input vec_t v);
        req_pool  = v.pool;
        req_port  = v.port;
        req_first = v.first;
        req_size  = v.size;
        req_addr  = v.addr;
        req_len   = v.len;
        req_shift = v.shift;
        req_mark  = v.mark;
    endtask

    // drive one request and check result, latency and busy
    task automatic run_req(input vec_t v, input string tag);
        int lat;
        bit busy_first;
        @(negedge clk);
        set_req(v);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        busy_first = busy_o;
        lat = 1;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(ok_o == v.eok, tag, "ok", 128'(ok_o), 128'(v.eok));
        if (v.eok)
            check(idx_o == v.eidx, tag, "idx", 128'(idx_o), 128'(v.eidx));
        // R5 latency: one candidate per cycle
        check(lat == int'(v.elat), "R5", "latency", 128'(lat), 128'(v.elat));
        check(busy_first == (v.elat > 1), "R5", "busy after accept",
              128'(busy_first), 128'(v.elat > 1));
        check(!busy_o, "R5", "busy at done", 128'(busy_o), 128'(0));
    endtask

    task automatic run_rel(input logic [6:0] f, input logic [7:0] c);
        @(negedge clk);
        rel_first = f;
        rel_count = c;
        rel_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] expv;
        vec_t tmp;
        int lat;
        rst = 1'b1;
        req_valid = 1'b0; req_pool = '0; req_port = '0; req_first = '0;
        req_size = '0; req_addr = '0; req_len = '0; req_shift = '0; req_mark = 1'b0;
        rel_valid = 1'b0; rel_first = '0; rel_count = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(valid_o == '0, "R1", "valid after reset", valid_o, '0);
        check(!busy_o && !done_o && !ok_o, "R1", "flags after reset",
              128'({busy_o, done_o, ok_o}), '0);

        for (int k = 0; k < NV; k++) run_req(VECS[k], vtag(k));

        // R7 marked runs present, unmarked ones absent
        expv = '0;
        expv[4:0]   = 5'b11111;
        expv[32]    = 1'b1;
        expv[66:64] = 3'b111;
        check(valid_o == expv, "R7", "vector after table", valid_o, expv);

        // R10 release 0..2
        run_rel(7'd0, 8'd3);
        expv[2:0] = 3'b000;
        check(valid_o == expv, "R10", "release three", valid_o, expv);

        // R10 zero-count release has no effect
        run_rel(7'd3, 8'd0);
        check(valid_o == expv, "R10", "release count zero", valid_o, expv);

        // R10 clipped release at the top of the table
        tmp = '{2'd0, 1'd0, 7'd126, 8'd2, 32'h0, 24'd32, 5'd4, 1'b1, 1'b1, 7'd126, 8'd2};
        run_req(tmp, "R10");
        expv[127:126] = 2'b11;
        check(valid_o == expv, "R10", "top entries marked", valid_o, expv);
        run_rel(7'd120, 8'd20);
        expv[127:126] = 2'b00;
        check(valid_o == expv, "R10", "clipped release", valid_o, expv);

        // R11 release and request during a busy search are ignored
        tmp = '{2'd0, 1'd0, 7'd3, 8'd10, 32'h0, 24'd1, 5'd4, 1'b0, 1'b1, 7'd5, 8'd4};
        @(negedge clk);
        set_req(tmp);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy_o, "R11", "busy during search", 128'(busy_o), 128'(1));
        rel_first = 7'd3; rel_count = 8'd2; rel_valid = 1'b1;
        req_pool = 2'd3; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        req_valid = 1'b0;
        lat = 2;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(ok_o && idx_o == 7'd5, "R11", "search result", 128'(idx_o), 128'(5));
        check(lat == 4, "R11", "search latency", 128'(lat), 128'(4));
        check(valid_o == expv, "R11", "release while busy ignored", valid_o, expv);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check(!done_o, "R11", "no result from ignored request", 128'(done_o), '0);
        end

        // R10 release and request in the same idle cycle
        tmp = '{2'd0, 1'd0, 7'd3, 8'd4, 32'h0, 24'd1, 5'd4, 1'b1, 1'b1, 7'd3, 8'd2};
        @(negedge clk);
        set_req(tmp);
        rel_first = 7'd3; rel_count = 8'd2;
        rel_valid = 1'b1;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        req_valid = 1'b0;
        lat = 1;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(ok_o && idx_o == 7'd3, "R10", "scan sees release", 128'(idx_o), 128'(3));
        check(lat == 2, "R10", "same-cycle latency", 128'(lat), 128'(2));
        expv[4:3] = 2'b01;
        check(valid_o == expv, "R10", "vector after same-cycle ops", valid_o, expv);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule